// File: doc/BRIEF.md
# Weighted Shortest-Path Hop Director

This block is a central route planner for a small two-dimensional mesh of nodes (4 by 4 by default). Every node carries a small busy weight, loaded through a configuration port, where 0 means idle and the largest value means heavily loaded. A node that wants to send raises its request line and places the destination node index on its own destination field. The planner accepts one request at a time, acknowledges it with a one-cycle grant, and then steps the route forward one hop per clock cycle. At each hop it issues a one-hot pass toward north, south, east, west or local for the node that currently holds the packet.

A hop is chosen by cost. The planner keeps a running-cost register for each node, and these registers are refilled from the fixed weights whenever a new route begins. Only neighbours that move the packet closer to the destination are considered, so each node has at most two candidates: one vertical and one horizontal. For each candidate the planner writes the current running cost plus that neighbour's fixed weight into the neighbour's running-cost register. It then moves to the cheaper of the two. When the packet reaches the destination, the planner issues a local pass and becomes free for the next request.

Nodes are numbered row-major: node n sits in row n / COLS and column n % COLS. Row 0 is the north edge and column 0 is the west edge.

Top module: `spr_router`

## Requirements
- R1: While reset is held and in the cycle after it is released, `grant` is all zeros and `pass_vld` is 0. All fixed weights reset to 0.
- R2: A cycle with `cfg_we` high loads `cfg_weight` into the fixed weight of node `cfg_node`. Routing never alters a fixed weight, so repeating a route with unchanged configuration gives the same passes.
- R3: When the planner is free, the lowest-numbered requesting node wins. Its `grant` bit is high for exactly one cycle, starting one cycle after the request was sampled, and at most one `grant` bit is ever high.
- R4: The first pass is valid in the cycle right after the grant. Each further pass follows in the next cycle. After a local pass, `pass_vld` is 0 in the next cycle.
- R5: The `pass_node` of each pass after the first is the neighbour that the previous pass pointed to. Every non-local pass reduces the row-plus-column distance to the destination by one, so a route whose endpoints are D apart produces exactly D non-local passes and then one local pass.
- R6: When both a vertical and a horizontal step are productive, the step with the smaller accumulated sum is taken. On equal sums the vertical step wins.
- R7: Accumulation starts at the source node's fixed weight. The `pass_acc` of a non-local pass equals the previous accumulated value plus the fixed weight of the chosen neighbour. That value is also stored in the chosen node's running-cost register. A local pass reports the accumulated value of the destination.
- R8: A request whose destination equals its source gets a grant and then a single local pass whose `pass_acc` is the source's fixed weight.
- R9: No grant is issued while a route is in progress. A request that is held during that time is served after the route's local pass.
- R10: `pass_dir` is one-hot while `pass_vld` is high. The bit encoding is: bit 0 local, bit 1 north (row - 1), bit 2 south (row + 1), bit 3 east (column + 1), bit 4 west (column - 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Fixed-weight write strobe |
| cfg_node | input | NW (4) | Node whose fixed weight is written |
| cfg_weight | input | WW (3) | Weight value to write |
| req | input | NODES (16) | Per-node route request, held until granted |
| req_dest | input | NODES*NW (64) | Per-node destination index; node n uses bits [n*NW +: NW] |
| grant | output | NODES (16) | One-cycle grant to the accepted node |
| pass_vld | output | 1 | A pass is being issued this cycle |
| pass_node | output | NW (4) | Node receiving the pass |
| pass_dir | output | 5 | One-hot direction, encoded as in R10 |
| pass_acc | output | AW (6) | Accumulated weight of the node the pass leads to |

## Verification
Every result is registered, and the timing is fixed. If a request is sampled at clock edge e0, the grant is visible after e0. Hop k is visible after edge e0+k. The local pass of a route whose endpoints are D apart is visible after e0+D+1, and the next grant can appear no earlier than after e0+D+2. The bench drives inputs and samples outputs on the falling edge. It follows this schedule exactly and compares the full pass record at each step with a route it computes from the weights it loaded. It sweeps every source and destination pair under several weight patterns, one of which forces a tie at every hop.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Bit positions within the one-hot pass direction
  localparam int P_LOCAL = 0;
  localparam int P_NORTH = 1;
  localparam int P_SOUTH = 2;
  localparam int P_EAST  = 3;
  localparam int P_WEST  = 4;
  localparam int DIR_W   = 5;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_ROUTE = 1'b1
  } route_state_e;

  function automatic int row_of(input int n, input int cols);
    return n / cols;
  endfunction

  function automatic int col_of(input int n, input int cols);
    return n % cols;
  endfunction

  // Largest accumulated sum along a minimal route: every node on the path at full weight
  function automatic int max_path_sum(input int rows, input int cols, input int ww);
    return (rows + cols - 1) * ((1 << ww) - 1);
  endfunction

endpackage

// File: rtl/spr_weight_bank.sv
module spr_weight_bank #(
  parameter int NODES = 16,
  parameter int NW    = 4,
  parameter int WW    = 3,
  parameter int AW    = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [NW-1:0]      cfg_node,
  input  logic [WW-1:0]      cfg_weight,
  input  logic               tmp_init,
  input  logic               wv_en,
  input  logic [NW-1:0]      wv_node,
  input  logic [AW-1:0]      wv_val,
  input  logic               wh_en,
  input  logic [NW-1:0]      wh_node,
  input  logic [AW-1:0]      wh_val,
  output logic [NODES*WW-1:0] perm_flat,
  output logic [NODES*AW-1:0] tmp_flat
);

  for (genvar g = 0; g < NODES; g++) begin : g_node
    logic [WW-1:0] perm_q;
    logic [AW-1:0] tmp_q;

    always_ff @(posedge clk) begin
      if (!rst_n)
        perm_q <= '0;
      else if (cfg_we && cfg_node == NW'(g))
        perm_q <= cfg_weight;
    end

    always_ff @(posedge clk) begin
      if (!rst_n)
        tmp_q <= '0;
      else if (tmp_init)
        tmp_q <= AW'(perm_q);
      else if (wv_en && wv_node == NW'(g))
        tmp_q <= wv_val;
      else if (wh_en && wh_node == NW'(g))
        tmp_q <= wh_val;
    end

    assign perm_flat[g*WW +: WW] = perm_q;
    assign tmp_flat[g*AW +: AW]  = tmp_q;
  end

endmodule

// File: rtl/spr_prio_pick.sv
module spr_prio_pick #(
  parameter int N  = 16,
  parameter int NW = 4
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  onehot,
  output logic [NW-1:0] idx,
  output logic          any
);

  // Walk from the top index down so the lowest requester is written last
  always_comb begin
    onehot = '0;
    idx    = '0;
    any    = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        onehot = N'(1) << i;
        idx    = NW'(i);
        any    = 1'b1;
      end
    end
  end

endmodule

// File: rtl/spr_hop_select.sv
module spr_hop_select
  import spr_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int NODES = 16,
  parameter int NW    = 4,
  parameter int WW    = 3,
  parameter int AW    = 6
) (
  input  logic [NW-1:0]       cur,
  input  logic [NW-1:0]       dst,
  input  logic [AW-1:0]       acc,
  input  logic [NODES*WW-1:0] perm_flat,
  output logic                at_dest,
  output logic                v_vld,
  output logic                h_vld,
  output logic [NW-1:0]       v_node,
  output logic [NW-1:0]       h_node,
  output logic [AW-1:0]       v_sum,
  output logic [AW-1:0]       h_sum,
  output logic [DIR_W-1:0]    dir,
  output logic [NW-1:0]       nxt,
  output logic [AW-1:0]       nxt_sum
);

  int cr, cc, dr, dc;
  logic take_v;

  assign cr = row_of(int'(cur), COLS);
  assign cc = col_of(int'(cur), COLS);
  assign dr = row_of(int'(dst), COLS);
  assign dc = col_of(int'(dst), COLS);

  assign at_dest = (cur == dst);
  assign v_vld   = (cr != dr);
  assign h_vld   = (cc != dc);

  // Only productive neighbours are candidates
  assign v_node = !v_vld ? cur : (dr > cr) ? NW'(int'(cur) + COLS) : NW'(int'(cur) - COLS);
  assign h_node = !h_vld ? cur : (dc > cc) ? NW'(int'(cur) + 1)    : NW'(int'(cur) - 1);

  assign v_sum = acc + AW'(perm_flat[int'(v_node)*WW +: WW]);
  assign h_sum = acc + AW'(perm_flat[int'(h_node)*WW +: WW]);

  // Vertical wins ties
  assign take_v = v_vld && (!h_vld || v_sum <= h_sum);

  assign nxt     = take_v ? v_node : h_node;
  assign nxt_sum = take_v ? v_sum  : h_sum;

  always_comb begin
    dir = '0;
    if (at_dest)
      dir[P_LOCAL] = 1'b1;
    else if (take_v)
      dir[(dr > cr) ? P_SOUTH : P_NORTH] = 1'b1;
    else
      dir[(dc > cc) ? P_EAST : P_WEST] = 1'b1;
  end

endmodule

// File: rtl/spr_router.sv
module spr_router
  import spr_pkg::*;
#(
  parameter  int ROWS  = 4,
  parameter  int COLS  = 4,
  parameter  int WW    = 3,
  localparam int NODES = ROWS * COLS,
  localparam int NW    = $clog2(NODES),
  localparam int AW    = $clog2(max_path_sum(ROWS, COLS, WW) + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic [NW-1:0]       cfg_node,
  input  logic [WW-1:0]       cfg_weight,
  input  logic [NODES-1:0]    req,
  input  logic [NODES*NW-1:0] req_dest,
  output logic [NODES-1:0]    grant,
  output logic                pass_vld,
  output logic [NW-1:0]       pass_node,
  output logic [DIR_W-1:0]    pass_dir,
  output logic [AW-1:0]       pass_acc
);

  route_state_e state_q;
  logic [NW-1:0] cur_q, dst_q;

  logic [NODES*WW-1:0] perm_flat;
  logic [NODES*AW-1:0] tmp_flat;
  logic [NODES-1:0]    pick_onehot;
  logic [NW-1:0]       pick_idx;
  logic                pick_any;

  logic                at_dest, v_vld, h_vld;
  logic [NW-1:0]       v_node, h_node, nxt;
  logic [AW-1:0]       v_sum, h_sum, nxt_sum, acc;
  logic [DIR_W-1:0]    dir;

  // Named internal events
  logic start_route, hop_fire, route_done;
  assign start_route = (state_q == ST_IDLE) && pick_any;
  assign hop_fire    = (state_q == ST_ROUTE);
  assign route_done  = hop_fire && at_dest;

  // The running cost of the node that holds the packet
  assign acc = tmp_flat[int'(cur_q)*AW +: AW];

  spr_prio_pick #(.N(NODES), .NW(NW)) pick_i (
    .req    (req),
    .onehot (pick_onehot),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  spr_weight_bank #(.NODES(NODES), .NW(NW), .WW(WW), .AW(AW)) bank_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_node   (cfg_node),
    .cfg_weight (cfg_weight),
    .tmp_init   (start_route),
    .wv_en      (hop_fire && v_vld),
    .wv_node    (v_node),
    .wv_val     (v_sum),
    .wh_en      (hop_fire && h_vld),
    .wh_node    (h_node),
    .wh_val     (h_sum),
    .perm_flat  (perm_flat),
    .tmp_flat   (tmp_flat)
  );

  spr_hop_select #(
    .ROWS(ROWS), .COLS(COLS), .NODES(NODES), .NW(NW), .WW(WW), .AW(AW)
  ) hop_i (
    .cur       (cur_q),
    .dst       (dst_q),
    .acc       (acc),
    .perm_flat (perm_flat),
    .at_dest   (at_dest),
    .v_vld     (v_vld),
    .h_vld     (h_vld),
    .v_node    (v_node),
    .h_node    (h_node),
    .v_sum     (v_sum),
    .h_sum     (h_sum),
    .dir       (dir),
    .nxt       (nxt),
    .nxt_sum   (nxt_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      cur_q     <= '0;
      dst_q     <= '0;
      grant     <= '0;
      pass_vld  <= 1'b0;
      pass_node <= '0;
      pass_dir  <= '0;
      pass_acc  <= '0;
    end else begin
      grant    <= '0;
      pass_vld <= 1'b0;
      if (start_route) begin
        grant   <= pick_onehot;
        cur_q   <= pick_idx;
        dst_q   <= req_dest[int'(pick_idx)*NW +: NW];
        state_q <= ST_ROUTE;
      end
      if (hop_fire) begin
        pass_vld  <= 1'b1;
        pass_node <= cur_q;
        pass_dir  <= dir;
        if (route_done) begin
          pass_acc <= acc;
          state_q  <= ST_IDLE;
        end else begin
          pass_acc <= nxt_sum;
          cur_q    <= nxt;
        end
      end
    end
  end

endmodule

// File: rtl/spr_router_chk.sv
module spr_router_chk #(
  parameter int NODES = 16,
  parameter int NW    = 4,
  parameter int AW    = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NODES-1:0]    grant,
  input logic                pass_vld,
  input logic [NW-1:0]       pass_node,
  input logic [4:0]          pass_dir,
  input logic [AW-1:0]       pass_acc,
  input logic [NODES*AW-1:0] tmp_flat
);

  // R3
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4
  grant_to_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |=> pass_vld);

  // R4
  hop_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vld && !pass_dir[0]) |=> pass_vld);

  // R4
  local_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vld && pass_dir[0]) |=> !pass_vld);

  // R10
  dir_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_vld |-> ($countones(pass_dir) == 1));

  // R9
  busy_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_vld |-> (grant == '0));

  // R7
  acc_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vld && !pass_dir[0]) |=> (pass_acc >= $past(pass_acc)));

  // R7
  tmp_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_vld && !pass_dir[0]) |=> (tmp_flat[int'(pass_node)*AW +: AW] == $past(pass_acc)));

endmodule

bind spr_router spr_router_chk #(.NODES(NODES), .NW(NW), .AW(AW)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .grant     (grant),
  .pass_vld  (pass_vld),
  .pass_node (pass_node),
  .pass_dir  (pass_dir),
  .pass_acc  (pass_acc),
  .tmp_flat  (tmp_flat)
);

// File: tb/spr_router_tb_top.sv
module spr_router_tb_top;

  localparam int R = 4;
  localparam int C = 4;
  localparam int N = R * C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_node = '0;
  logic [2:0]  cfg_weight = '0;
  logic [N-1:0]   req = '0;
  logic [N*4-1:0] req_dest = '0;
  logic [N-1:0]   grant;
  logic        pass_vld;
  logic [3:0]  pass_node;
  logic [4:0]  pass_dir;
  logic [5:0]  pass_acc;

  int checks = 0;
  int fails  = 0;
  int w[N];
  bit done = 1'b0;

  always #2 clk = ~clk;

  spr_router #(.ROWS(R), .COLS(C), .WW(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_node(cfg_node),
    .cfg_weight(cfg_weight), .req(req), .req_dest(req_dest), .grant(grant),
    .pass_vld(pass_vld), .pass_node(pass_node), .pass_dir(pass_dir), .pass_acc(pass_acc)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_weights(input int mode);
    for (int n = 0; n < N; n++) begin
      case (mode)
        0: w[n] = 0;
        1: w[n] = (n * 5 + 3) % 8;
        2: w[n] = ((n / C) * 3 + (n % C) * 6 + 1) % 8;
        default: w[n] = 7 - (n % 8);
      endcase
      @(negedge clk);
      cfg_we = 1'b1; cfg_node = 4'(n); cfg_weight = 3'(w[n]);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Checks passes from the cycle after the grant; returns the final accumulated value
  task automatic follow(input int src, input int dst, output int acc_out);
    int cur = src;
    int acc = w[src];
    forever begin
      int r = cur / C, c = cur % C, dr = dst / C, dc = dst % C;
      int nx, dirb, sv, sh, vn, hn;
      logic [15:0] exp_v, act_v;
      @(negedge clk);
      if (cur == dst) begin
        nx = cur; dirb = 0;
      end else begin
        vn = (dr > r) ? cur + C : cur - C;
        hn = (dc > c) ? cur + 1 : cur - 1;
        sv = acc + w[vn];
        sh = acc + w[hn];
        if (r != dr && (c == dc || sv <= sh)) begin
          nx = vn; dirb = (dr > r) ? 2 : 1; acc = sv;
        end else begin
          nx = hn; dirb = (dc > c) ? 3 : 4; acc = sh;
        end
      end
      exp_v = {1'b1, 4'(cur), 5'(1 << dirb), 6'(acc)};
      act_v = {pass_vld, pass_node, pass_dir, pass_acc};
      // R4 R5 R6 R7 R8 R10: full pass record per hop
      chk(act_v == exp_v, $sformatf("R5/R6/R7 hop %0d->%0d at %0d", src, dst, cur), 32'(act_v), 32'(exp_v));
      chk(grant == '0, "R9 grant during route", 32'(grant), 0);
      if (cur == dst) break;
      cur = nx;
    end
    acc_out = acc;
  endtask

  task automatic do_route(input int src, input int dst, output int acc_out);
    @(negedge clk);
    req[src] = 1'b1;
    req_dest[src*4 +: 4] = 4'(dst);
    @(negedge clk);
    // R3: grant one cycle after the request is sampled
    chk(grant == N'(1) << src, "R3 grant", 32'(grant), 32'(1) << src);
    req[src] = 1'b0;
    follow(src, dst, acc_out);
    @(negedge clk);
    // R4: idle after local pass
    chk(!pass_vld, "R4 idle after local", 32'(pass_vld), 0);
  endtask

  initial begin
    int a1, a2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(grant == '0 && !pass_vld, "R1 during reset", {grant, 15'd0, pass_vld}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(grant == '0 && !pass_vld, "R1 after release", {grant, 15'd0, pass_vld}, 0);
    for (int n = 0; n < N; n++) w[n] = 0;
    // R1: fixed weights cleared, route sums to 0
    do_route(0, 15, a1);
    chk(a1 == 0, "R1 weights reset", 32'(a1), 0);

    // Sweeps: mode 0 forces ties everywhere (R6), R8 covered by src==dst
    for (int m = 0; m < 4; m++) begin
      load_weights(m);
      for (int s = 0; s < N; s++)
        for (int d = 0; d < N; d++)
          do_route(s, d, a1);
      // R2: routing left fixed weights untouched
      do_route(3, 12, a1);
      do_route(3, 12, a2);
      chk(a1 == a2, "R2 repeat route", 32'(a2), 32'(a1));
    end

    // R3 / R9: two simultaneous requests, lowest index first, other deferred
    load_weights(1);
    @(negedge clk);
    req[9] = 1'b1; req_dest[9*4 +: 4] = 4'd0;
    req[5] = 1'b1; req_dest[5*4 +: 4] = 4'd15;
    @(negedge clk);
    chk(grant == N'(1) << 5, "R3 priority", 32'(grant), 32'(1) << 5);
    req[5] = 1'b0;
    follow(5, 15, a1);
    @(negedge clk);
    chk(grant == N'(1) << 9, "R9 deferred grant", 32'(grant), 32'(1) << 9);
    req[9] = 1'b0;
    follow(9, 0, a1);
    @(negedge clk);
    chk(grant == '0 && !pass_vld, "R3 single grant", 32'(grant), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule